// File: doc/BRIEF.md
# Digital PID Duty-Cycle Compensator

This block is the discrete-time compensator inside a voltage-mode buck regulator. The block samples a signed error word from the front end once per switching period. From that sample and the recent history it forms a new duty-cycle command. The command comes from a two-pole/two-zero difference equation with five programmable coefficients: three taps on the error history and two taps on the output history. The internal datapath is 17 bits, signed.

The error word can be refined by a fine-trim value. When fine mode is on, one coarse error step is worth five fine steps. The command can also be divided by the measured supply voltage, which gives input-voltage feed-forward. The division is done as a multiply by a reciprocal that is looked up from the top bits of the supply word. The result is clamped to a non-negative duty word and presented with a one-cycle valid strobe, ready for a digital PWM generator.

Top module: `pid_duty_comp`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `duty_vld_o` is 0 and `duty_o` is 0. All error and output history is zero.
- R2: A strobe on `sample_i` with `en_i` high is accepted at a rising edge. `duty_vld_o` is then high for exactly one cycle, after the third rising edge counted from and including the accepting edge. Strobes must be at least three cycles apart.
- R3: The conditioned error is `5*err_i + trim_i`, with `trim_i` signed, when `fine_en_i` is 1. When `fine_en_i` is 0 it is `5*err_i`, and `trim_i` has no effect.
- R4: The accumulator is `b0*x[n] + b1*x[n-1] + b2*x[n-2] + a1*u[n-1] + a2*u[n-2]`. Here x is the conditioned error and the coefficients are signed 16-bit values with 12 fractional bits. The command u[n] is the accumulator shifted right arithmetically by 12 bits, which rounds toward minus infinity.
- R5: u[n] saturates to the range -65536..65535. The saturated value, not the raw one, is stored as output history, so recovery from saturation begins on the very next sample.
- R6: With `ff_en_i` at 0, `duty_o` is u[n] clamped to 0..65535.
- R7: With `ff_en_i` at 1, let k be the value of bits [11:7] of `vin_i`. Let r = floor(4096 / max(k,1)). Then `duty_o` is floor(u[n]*r/256) clamped to 0..65535. The value k = 16 gives unity gain.
- R8: With `en_i` low, the error and output history are cleared to zero, any computation in flight is cancelled, and strobes are ignored.
- R9: `duty_o` holds its value in every cycle in which `duty_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Compensator enable; low clears the history |
| sample_i | input | 1 | One-cycle strobe that starts a computation |
| err_i | input | 12 | Signed error sample |
| fine_en_i | input | 1 | Enables the fine trim |
| trim_i | input | 3 | Signed fine trim, in fifths of an error step |
| vin_i | input | 12 | Unsigned supply-voltage sample |
| ff_en_i | input | 1 | Enables supply feed-forward |
| coef_b0_i | input | 16 | Coefficient on x[n] |
| coef_b1_i | input | 16 | Coefficient on x[n-1] |
| coef_b2_i | input | 16 | Coefficient on x[n-2] |
| coef_a1_i | input | 16 | Coefficient on u[n-1] |
| coef_a2_i | input | 16 | Coefficient on u[n-2] |
| duty_o | output | 16 | Duty-cycle command, unsigned |
| duty_vld_o | output | 1 | One-cycle strobe marking a new duty word |

## Verification
The checker assumes that strobes on `sample_i` never arrive on consecutive cycles, or two cycles apart. This spacing keeps the output history current before the next accumulation begins. The latency, single-pulse and hold properties rely on that spacing.

The directed stimulus raises `sample_i` for one cycle per scenario. It then lets at least four idle cycles pass before the next strobe. Coefficients, supply and mode inputs change only between computations. Enable drops only in the idle gaps, except in the one scenario that checks that a strobe is ignored while the block is disabled.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int PID_DW    = 17;  // datapath width
  localparam int PID_CW    = 16;  // coefficient width
  localparam int PID_FRAC  = 12;  // coefficient fractional bits
  localparam int PID_EW    = 12;  // error input width
  localparam int PID_TW    = 3;   // fine trim width
  localparam int PID_VW    = 12;  // supply word width
  localparam int PID_LB    = 5;   // reciprocal index bits
  localparam int PID_RB    = 8;   // reciprocal fractional bits
  localparam int PID_NTAPS = 5;

  typedef enum logic [2:0] {
    TAP_X0 = 3'd0,
    TAP_X1 = 3'd1,
    TAP_X2 = 3'd2,
    TAP_U1 = 3'd3,
    TAP_U2 = 3'd4
  } tap_e;
endpackage

// File: rtl/pid_recip_rom.sv
module pid_recip_rom #(
  parameter int LB = 5,
  parameter int RB = 8,
  localparam int RW = RB + LB,
  localparam int NE = 1 << LB
) (
  input  logic [LB-1:0] idx_i,
  output logic [RW-1:0] rcp_o
);
  logic [RW-1:0] tbl [NE];

  for (genvar g = 0; g < NE; g++) begin : g_ent
    localparam int DEN = (g == 0) ? 1 : g;
    localparam int VAL = (1 << (RB + LB - 1)) / DEN;
    assign tbl[g] = RW'(VAL);
  end

  assign rcp_o = tbl[idx_i];
endmodule

// File: rtl/pid_mac.sv
module pid_mac
  import pid_pkg::*;
#(
  parameter int DW = PID_DW,
  parameter int CW = PID_CW,
  parameter int EW = PID_EW,
  parameter int TW = PID_TW,
  parameter int VW = PID_VW,
  parameter int LB = PID_LB,
  localparam int AW = DW + CW + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_i,
  input  logic                 start_i,
  input  logic [EW-1:0]        err_i,
  input  logic                 fine_en_i,
  input  logic [TW-1:0]        trim_i,
  input  logic [VW-1:0]        vin_i,
  input  logic                 ff_en_i,
  input  logic [CW-1:0]        cb0_i,
  input  logic [CW-1:0]        cb1_i,
  input  logic [CW-1:0]        cb2_i,
  input  logic [CW-1:0]        ca1_i,
  input  logic [CW-1:0]        ca2_i,
  input  logic signed [DW-1:0] u1_i,
  input  logic signed [DW-1:0] u2_i,
  output logic signed [AW-1:0] acc_o,
  output logic [LB-1:0]        idx_o,
  output logic                 ff_o,
  output logic                 vld_o
);
  logic signed [DW-1:0] err_x, trim_x, eff;
  logic signed [DW-1:0] e1_q, e2_q;
  logic signed [DW-1:0] tap [PID_NTAPS];
  logic [CW-1:0]        cf  [PID_NTAPS];
  logic signed [AW-1:0] prd [PID_NTAPS];
  logic signed [AW-1:0] sum;

  always_comb begin
    err_x  = {{(DW-EW){err_i[EW-1]}}, err_i};
    trim_x = fine_en_i ? {{(DW-TW){trim_i[TW-1]}}, trim_i} : '0;
    eff    = (err_x <<< 2) + err_x + trim_x;
  end

  assign tap[TAP_X0] = eff;
  assign tap[TAP_X1] = e1_q;
  assign tap[TAP_X2] = e2_q;
  assign tap[TAP_U1] = u1_i;
  assign tap[TAP_U2] = u2_i;
  assign cf[TAP_X0]  = cb0_i;
  assign cf[TAP_X1]  = cb1_i;
  assign cf[TAP_X2]  = cb2_i;
  assign cf[TAP_U1]  = ca1_i;
  assign cf[TAP_U2]  = ca2_i;

  for (genvar g = 0; g < PID_NTAPS; g++) begin : g_tap
    assign prd[g] = $signed({{(AW-DW){tap[g][DW-1]}}, tap[g]}) *
                    $signed({{(AW-CW){cf[g][CW-1]}}, cf[g]});
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < PID_NTAPS; i++) sum = sum + prd[i];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      e1_q  <= '0;
      e2_q  <= '0;
      acc_o <= '0;
      idx_o <= '0;
      ff_o  <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= start_i;
      if (start_i) begin
        acc_o <= sum;
        e1_q  <= eff;
        e2_q  <= e1_q;
        idx_o <= vin_i[VW-1 -: LB];
        ff_o  <= ff_en_i;
      end
    end
  end
endmodule

// File: rtl/pid_shaper.sv
module pid_shaper
  import pid_pkg::*;
#(
  parameter int DW   = PID_DW,
  parameter int CW   = PID_CW,
  parameter int FRAC = PID_FRAC,
  parameter int LB   = PID_LB,
  parameter int RB   = PID_RB,
  localparam int AW  = DW + CW + 3,
  localparam int RW  = RB + LB,
  localparam int PW  = DW + RW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_i,
  input  logic                 vld_i,
  input  logic signed [AW-1:0] acc_i,
  input  logic [LB-1:0]        idx_i,
  input  logic                 ff_i,
  output logic signed [DW-1:0] u1_o,
  output logic signed [DW-1:0] u2_o,
  output logic signed [PW-1:0] prod_o,
  output logic                 vld_o
);
  localparam logic signed [AW-1:0] UMAX = AW'((1 << (DW - 1)) - 1);
  localparam logic signed [AW-1:0] UMIN = -AW'(1 << (DW - 1));

  logic signed [AW-1:0] shr;
  logic signed [DW-1:0] u_sat;
  logic [RW-1:0]        rcp;
  logic signed [PW-1:0] u_x, rcp_x;

  pid_recip_rom #(.LB(LB), .RB(RB)) u_rom (
    .idx_i (idx_i),
    .rcp_o (rcp)
  );

  always_comb begin
    shr = acc_i >>> FRAC;
    if (shr > UMAX)      u_sat = UMAX[DW-1:0];
    else if (shr < UMIN) u_sat = UMIN[DW-1:0];
    else                 u_sat = shr[DW-1:0];
    u_x   = {{(PW-DW){u_sat[DW-1]}}, u_sat};
    rcp_x = {{(PW-RW){1'b0}}, rcp};
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      u1_o   <= '0;
      u2_o   <= '0;
      prod_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        u1_o   <= u_sat;
        u2_o   <= u1_o;
        prod_o <= ff_i ? u_x * rcp_x : (u_x <<< RB);
      end
    end
  end
endmodule

// File: rtl/pid_duty_comp.sv
module pid_duty_comp
  import pid_pkg::*;
#(
  parameter int DW   = PID_DW,
  parameter int CW   = PID_CW,
  parameter int FRAC = PID_FRAC,
  parameter int EW   = PID_EW,
  parameter int TW   = PID_TW,
  parameter int VW   = PID_VW,
  parameter int LB   = PID_LB,
  parameter int RB   = PID_RB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          sample_i,
  input  logic [EW-1:0] err_i,
  input  logic          fine_en_i,
  input  logic [TW-1:0] trim_i,
  input  logic [VW-1:0] vin_i,
  input  logic          ff_en_i,
  input  logic [CW-1:0] coef_b0_i,
  input  logic [CW-1:0] coef_b1_i,
  input  logic [CW-1:0] coef_b2_i,
  input  logic [CW-1:0] coef_a1_i,
  input  logic [CW-1:0] coef_a2_i,
  output logic [DW-2:0] duty_o,
  output logic          duty_vld_o
);
  localparam int AW = DW + CW + 3;
  localparam int PW = DW + RB + LB + 1;
  localparam logic signed [PW-1:0] DMAX = PW'((1 << (DW - 1)) - 1);

  logic                 clr;
  logic signed [AW-1:0] acc;
  logic [LB-1:0]        idx;
  logic                 ff, vld1, vld2;
  logic signed [DW-1:0] u1, u2;
  logic signed [PW-1:0] prod, scl;

  assign clr = ~en_i;

  pid_mac #(
    .DW(DW), .CW(CW), .EW(EW), .TW(TW), .VW(VW), .LB(LB)
  ) u_mac (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr),
    .start_i   (sample_i),
    .err_i     (err_i),
    .fine_en_i (fine_en_i),
    .trim_i    (trim_i),
    .vin_i     (vin_i),
    .ff_en_i   (ff_en_i),
    .cb0_i     (coef_b0_i),
    .cb1_i     (coef_b1_i),
    .cb2_i     (coef_b2_i),
    .ca1_i     (coef_a1_i),
    .ca2_i     (coef_a2_i),
    .u1_i      (u1),
    .u2_i      (u2),
    .acc_o     (acc),
    .idx_o     (idx),
    .ff_o      (ff),
    .vld_o     (vld1)
  );

  pid_shaper #(
    .DW(DW), .CW(CW), .FRAC(FRAC), .LB(LB), .RB(RB)
  ) u_shp (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .vld_i  (vld1),
    .acc_i  (acc),
    .idx_i  (idx),
    .ff_i   (ff),
    .u1_o   (u1),
    .u2_o   (u2),
    .prod_o (prod),
    .vld_o  (vld2)
  );

  assign scl = prod >>> RB;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_o     <= '0;
      duty_vld_o <= 1'b0;
    end else begin
      duty_vld_o <= vld2 & en_i;
      if (vld2 && en_i) begin
        if (scl < 0)         duty_o <= '0;
        else if (scl > DMAX) duty_o <= DMAX[DW-2:0];
        else                 duty_o <= scl[DW-2:0];
      end
    end
  end
endmodule

// File: rtl/pid_duty_comp_chk.sv
module pid_duty_comp_chk #(
  parameter int DW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          en_i,
  input logic          sample_i,
  input logic [DW-2:0] duty_o,
  input logic          duty_vld_o
);
  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    sample_i |-> (!$past(sample_i, 1) && !$past(sample_i, 2)));

  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    duty_vld_o |-> $past(sample_i && en_i, 3));

  // R2
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    duty_vld_o |=> !duty_vld_o);

  // R8
  disable_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !duty_vld_o);

  // R9
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !duty_vld_o |-> $stable(duty_o));
endmodule

bind pid_duty_comp pid_duty_comp_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_i       (en_i),
  .sample_i   (sample_i),
  .duty_o     (duty_o),
  .duty_vld_o (duty_vld_o)
);

// File: tb/pid_duty_comp_tb.sv
module pid_duty_comp_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0;
  logic        sample_i = 1'b0;
  logic [11:0] err_i = '0;
  logic        fine_en_i = 1'b0;
  logic [2:0]  trim_i = '0;
  logic [11:0] vin_i = '0;
  logic        ff_en_i = 1'b0;
  logic [15:0] cb0 = '0, cb1 = '0, cb2 = '0, ca1 = '0, ca2 = '0;
  logic [15:0] duty_o;
  logic        duty_vld_o;

  int checks = 0;
  int errors = 0;
  longint m_e1 = 0, m_e2 = 0, m_u1 = 0, m_u2 = 0;

  always #2 clk = ~clk;

  pid_duty_comp u_dut (
    .clk(clk), .rst(rst), .en_i(en_i), .sample_i(sample_i),
    .err_i(err_i), .fine_en_i(fine_en_i), .trim_i(trim_i),
    .vin_i(vin_i), .ff_en_i(ff_en_i),
    .coef_b0_i(cb0), .coef_b1_i(cb1), .coef_b2_i(cb2),
    .coef_a1_i(ca1), .coef_a2_i(ca2),
    .duty_o(duty_o), .duty_vld_o(duty_vld_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint clampl(input longint v, input longint lo, input longint hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  // model built from R3..R7
  function automatic longint model_step(input longint err, input longint trim,
                                        input bit fine, input longint vin, input bit ff);
    longint x, acc, u, k, r, p;
    x   = 5 * err + (fine ? trim : 0);
    acc = longint'($signed(cb0)) * x + longint'($signed(cb1)) * m_e1 +
          longint'($signed(cb2)) * m_e2 + longint'($signed(ca1)) * m_u1 +
          longint'($signed(ca2)) * m_u2;
    u   = clampl(acc >>> 12, -65536, 65535);
    m_e2 = m_e1; m_e1 = x; m_u2 = m_u1; m_u1 = u;
    if (ff) begin
      k = (vin >> 7) & 31;
      r = 4096 / ((k == 0) ? 1 : k);
      p = (u * r) >>> 8;
    end else p = u;
    return clampl(p, 0, 65535);
  endfunction

  task automatic set_coefs(input int b0, input int b1, input int b2, input int a1, input int a2);
    cb0 = 16'(b0); cb1 = 16'(b1); cb2 = 16'(b2); ca1 = 16'(a1); ca2 = 16'(a2);
  endtask

  task automatic clear_hist();
    @(negedge clk); en_i = 1'b0;
    @(negedge clk); en_i = 1'b1;
    m_e1 = 0; m_e2 = 0; m_u1 = 0; m_u2 = 0;
  endtask

  task automatic run_sample(input string req, input int err, input int trim,
                            input bit fine, input int vin, input bit ff,
                            output longint got);
    longint exp;
    @(negedge clk);
    err_i = 12'(err); trim_i = 3'(trim); fine_en_i = fine;
    vin_i = 12'(vin); ff_en_i = ff; sample_i = 1'b1;
    exp = model_step(err, trim, fine, vin, ff);
    @(negedge clk); sample_i = 1'b0;
    check("R2 vld early", duty_vld_o, 0);
    @(negedge clk);
    check("R2 vld early", duty_vld_o, 0);
    @(negedge clk);
    check("R2 vld on time", duty_vld_o, 1);
    check(req, duty_o, exp);
    got = longint'(duty_o);
    @(negedge clk);
    check("R2 single pulse", duty_vld_o, 0);
    check("R9 hold", duty_o, got);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 vld", duty_vld_o, 0);
    check("R1 duty", duty_o, 0);
  endtask

  task automatic t_prop();
    longint g;
    set_coefs(4096, 0, 0, 0, 0); clear_hist();
    run_sample("R6 prop", 100, 0, 0, 0, 0, g);
    check("R6 prop literal", g, 500);
    run_sample("R6 neg clamp", -40, 0, 0, 0, 0, g);
    check("R6 neg clamp literal", g, 0);
  endtask

  task automatic t_fine();
    longint g;
    set_coefs(4096, 0, 0, 0, 0); clear_hist();
    run_sample("R3 trim ignored", 10, 3, 0, 0, 0, g);
    check("R3 trim ignored literal", g, 50);
    run_sample("R3 trim applied", 10, -2, 1, 0, 0, g);
    check("R3 trim applied literal", g, 48);
  endtask

  task automatic t_integ();
    longint g;
    set_coefs(4096, 0, 0, 4096, 0); clear_hist();
    for (int i = 1; i <= 3; i++) begin
      run_sample("R4 integrate", 100, 0, 0, 0, 0, g);
      check("R4 integrate literal", g, 500 * i);
    end
  endtask

  task automatic t_sat();
    longint g;
    set_coefs(4096, 0, 0, 4096, 0); clear_hist();
    for (int i = 0; i < 8; i++) run_sample("R5 saturate", 2047, 0, 0, 0, 0, g);
    check("R5 saturated", g, 65535);
    run_sample("R5 no windup", -2047, 0, 0, 0, 0, g);
    check("R5 no windup literal", g, 55300);
  endtask

  task automatic t_mix();
    longint g;
    set_coefs(5000, -3000, 800, 3500, -700); clear_hist();
    run_sample("R4 mix a", 300, 0, 0, 0, 0, g);
    run_sample("R4 mix b", -120, 0, 0, 0, 0, g);
    run_sample("R4 mix c", 450, 1, 1, 0, 0, g);
    run_sample("R4 mix d", 77, 0, 0, 0, 0, g);
    run_sample("R4 mix e", -5, 0, 0, 0, 0, g);
  endtask

  task automatic t_ff();
    longint g;
    set_coefs(4096, 0, 0, 0, 0); clear_hist();
    run_sample("R7 half supply", 100, 0, 0, 8 << 7, 1, g);
    check("R7 half supply literal", g, 1000);
    run_sample("R7 unity", 100, 0, 0, (16 << 7) | 127, 1, g);
    check("R7 unity literal", g, 500);
    run_sample("R7 index zero", 100, 0, 0, 5, 1, g);
    check("R7 index zero literal", g, 8000);
    run_sample("R7 top index", 100, 0, 0, 31 << 7, 1, g);
    check("R7 top index literal", g, 257);
    run_sample("R7 clamp", 2000, 0, 0, 1 << 7, 1, g);
    check("R7 clamp literal", g, 65535);
  endtask

  task automatic t_disable();
    longint g, held;
    set_coefs(4096, 0, 0, 4096, 0); clear_hist();
    run_sample("R8 prime", 100, 0, 0, 0, 0, g);
    held = g;
    @(negedge clk); en_i = 1'b0; sample_i = 1'b1; err_i = 12'd300;
    @(negedge clk); sample_i = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check("R8 strobe ignored", duty_vld_o, 0);
      check("R9 hold while disabled", duty_o, held);
    end
    en_i = 1'b1;
    m_e1 = 0; m_e2 = 0; m_u1 = 0; m_u2 = 0;
    run_sample("R8 history cleared", 100, 0, 0, 0, 0, g);
    check("R8 history cleared literal", g, 500);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    en_i = 1'b1;
    t_prop();
    t_fine();
    t_integ();
    t_sat();
    t_mix();
    t_ff();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule